// File: doc/BRIEF.md
# Indexed-Colour Display Register File

This block holds the software-visible state of an 8-bit indexed-colour display controller behind a 32-bit word-access bus. It stores a 256-entry RGB colour lookup table, a 3-entry cursor colour table, a 512-entry store of 16-bit cursor pattern words, a cursor position, a control word, a screen start offset, and the active width and height. A pixel pipeline reads these over dedicated lookup ports and decoded outputs.

Each bus request is a single-cycle pulse on `reqValid`. A write takes effect on the clock edge that accepts it. The response, `rspReady`, together with any read data, comes one cycle later. Width and height sit on the bus in scaled encodings. The table entries are spaced eight bytes apart, so the low three address bits inside an entry are ignored.

A frame-start strobe raises an interrupt, and any bus write lowers it. A write to a reserved high address returns every piece of stored state to zero. Writes to the video timing offsets are accepted and change nothing.

Top module: `dcr_top`

## Requirements
- R1: After every accepted request (`reqValid` high at a clock edge), `rspReady` is high for exactly the following cycle. Otherwise it is low. On a read, `rspRdata` holds the result in that same cycle.
- R2: Writing value v at offset 0x118 stores width = v×4, truncated to 32 bits, and `activeWidth` shows it. A read at 0x118 returns width shifted right by 2.
- R3: Writing value v at offset 0x150 stores height = v>>1, and `activeHeight` shows it. A read at 0x150 returns height shifted left by 1, truncated to 32 bits.
- R4: A write in the range 0x800–0xFFF sets colour entry (addr−0x800)>>3. Red comes from data bits 23:16, green from 15:8 and blue from 7:0. `palRgb` shows entry `palIdx` with the same packing. Bus reads in this range return 0.
- R5: Cursor colour entry i (0..2) lives at 0x508+8·i. It can be written and read on the bus, and it uses the RGB packing of R4. `curPalRgb` shows entry `curPalIdx`, and index 3 yields 0.
- R6: A write in the range 0x1000–0x1FFF stores data bits 15:0 into pattern word (addr−0x1000)>>3. A bus read returns that word zero-extended. `patWord` shows word `patIdx`.
- R7: The control word at 0x300 can be written and read, and `ctlWord` shows it. `forceBlank` is bit 10 and `cursorOff` is bit 23. `pixDepth` decodes bits 22:20 as code 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0.
- R8: Writes at 0x400 drive `screenTop`, and writes at 0x638 drive `cursorPos`. Both offsets read as 0. Every offset without a readable register also reads as 0, including 0x520 and the reset address.
- R9: Writes at 0x000, 0x200, and the 8-byte-aligned offsets 0x108–0x170 other than 0x118 and 0x150 change no output and no readable state. Writes at any other undefined offset behave the same way.
- R10: `frameIrq` rises on the edge after `frameStrobe` is sampled high. It falls on the edge after any bus write, including writes to ignored offsets. When a strobe and a write fall in the same cycle, the strobe wins. Reads leave it unchanged.
- R11: A write at 0x100000 clears every colour entry, cursor colour, pattern word, the cursor position, control word, screen start, width and height. The write also lowers `frameIrq`, as R10 requires.
- R12: While `rstN` is low, all stored state, `frameIrq`, `rspReady` and `rspRdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Single-cycle bus request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (21) | Byte offset of the access |
| reqWdata | input | DATA_W (32) | Write data |
| rspReady | output | 1 | Response strobe, one cycle after a request |
| rspRdata | output | DATA_W (32) | Read data, valid with rspReady |
| frameStrobe | input | 1 | Start-of-frame pulse |
| frameIrq | output | 1 | Frame interrupt |
| ctlWord | output | DATA_W (32) | Stored control word |
| pixDepth | output | 5 | Decoded bits per pixel |
| forceBlank | output | 1 | Blank request from the control word |
| cursorOff | output | 1 | Cursor disable from the control word |
| screenTop | output | DATA_W (32) | Screen start offset |
| cursorPos | output | DATA_W (32) | Cursor position word |
| activeWidth | output | DATA_W (32) | Stored width in pixels |
| activeHeight | output | DATA_W (32) | Stored height in lines |
| palIdx | input | log2(PAL_N) (8) | Colour table lookup index |
| palRgb | output | 24 | Colour table entry at palIdx |
| curPalIdx | input | log2(CURPAL_N+1) (2) | Cursor colour lookup index |
| curPalRgb | output | 24 | Cursor colour at curPalIdx |
| patIdx | input | log2(PAT_N) (9) | Pattern lookup index |
| patWord | output | 16 | Pattern word at patIdx |

## Verification
The bench builds the block with its defaults: a 21-bit address, 32-bit data, 256 colour entries, 512 pattern words and 3 cursor colours. With these values the top entries of both tables (0xFF8 and 0x1FF8), the unused fourth cursor colour slot, and the reset address at bit 20 can all be reached on real offsets. The bench also drives the full 32-bit data path, so overflow of the width scaling and the loss of the height's low bit show up.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int unsigned STB_IDX_W   = 9;
  localparam int unsigned ENTRY_SHIFT = 3;
  localparam int unsigned RGB_W       = 24;
  localparam int unsigned PAT_W       = 16;
  localparam int unsigned DEPTH_W     = 5;

  localparam logic [31:0] OFF_HDISP  = 32'h0000_0118;
  localparam logic [31:0] OFF_VDISP  = 32'h0000_0150;
  localparam logic [31:0] OFF_CTL    = 32'h0000_0300;
  localparam logic [31:0] OFF_TOP    = 32'h0000_0400;
  localparam logic [31:0] OFF_CURPAL = 32'h0000_0508;
  localparam logic [31:0] OFF_CURPOS = 32'h0000_0638;
  localparam logic [31:0] OFF_PAL    = 32'h0000_0800;
  localparam logic [31:0] OFF_PAT    = 32'h0000_1000;
  localparam logic [31:0] OFF_SRST   = 32'h0010_0000;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_WIDTH,
    RD_HEIGHT,
    RD_CTL,
    RD_CURPAL,
    RD_PAT
  } rdSel_e;

  // Strobes from the decoder to the storage datapath, valid for one cycle.
  typedef struct packed {
    logic                 wrWidth;
    logic                 wrHeight;
    logic                 wrCtl;
    logic                 wrTop;
    logic                 wrCurPos;
    logic                 wrPal;
    logic                 wrCurPal;
    logic                 wrPat;
    logic                 softReset;
    rdSel_e               rdSel;
    logic [STB_IDX_W-1:0] idx;
  } regStrobe_t;

  function automatic logic [DEPTH_W-1:0] depthOf(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl import dcr_pkg::*; #(
  parameter int ADDR_W   = 21,
  parameter int PAL_N    = 256,
  parameter int PAT_N    = 512,
  parameter int CURPAL_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              frameStrobe,
  output regStrobe_t        strb,
  output logic              rspReady,
  output logic              frameIrq
);

  localparam logic [31:0] PAL_END    = OFF_PAL    + (32'(PAL_N)    << ENTRY_SHIFT);
  localparam logic [31:0] PAT_END    = OFF_PAT    + (32'(PAT_N)    << ENTRY_SHIFT);
  localparam logic [31:0] CURPAL_END = OFF_CURPAL + (32'(CURPAL_N) << ENTRY_SHIFT);

  logic [31:0] addr32;
  logic        hitPal, hitCurPal, hitPat, hitTiming;
  logic [31:0] regionBase;
  logic        doWr, doRd;

  assign addr32 = 32'(reqAddr);
  assign doWr   = reqValid & reqWrite;
  assign doRd   = reqValid & ~reqWrite;

  always_comb begin
    hitPal    = (addr32 >= OFF_PAL)    && (addr32 < PAL_END);
    hitPat    = (addr32 >= OFF_PAT)    && (addr32 < PAT_END);
    hitCurPal = (addr32 >= OFF_CURPAL) && (addr32 < CURPAL_END);
    hitTiming = (addr32 == 32'h0) || (addr32 == 32'h200) ||
                ((addr32 >= 32'h108) && (addr32 <= 32'h170) && (addr32[2:0] == 3'b000) &&
                 (addr32 != OFF_HDISP) && (addr32 != OFF_VDISP));
    if (hitPal)         regionBase = OFF_PAL;
    else if (hitPat)    regionBase = OFF_PAT;
    else if (hitCurPal) regionBase = OFF_CURPAL;
    else                regionBase = addr32;
  end

  always_comb begin
    strb           = '0;
    strb.idx       = STB_IDX_W'((addr32 - regionBase) >> ENTRY_SHIFT);
    strb.wrWidth   = doWr && (addr32 == OFF_HDISP);
    strb.wrHeight  = doWr && (addr32 == OFF_VDISP);
    strb.wrCtl     = doWr && (addr32 == OFF_CTL);
    strb.wrTop     = doWr && (addr32 == OFF_TOP);
    strb.wrCurPos  = doWr && (addr32 == OFF_CURPOS);
    strb.softReset = doWr && (addr32 == OFF_SRST);
    strb.wrPal     = doWr && hitPal;
    strb.wrPat     = doWr && hitPat;
    strb.wrCurPal  = doWr && hitCurPal;
    strb.rdSel     = RD_NONE;
    if (doRd) begin
      if (hitCurPal)                 strb.rdSel = RD_CURPAL;
      else if (hitPat)               strb.rdSel = RD_PAT;
      else if (addr32 == OFF_HDISP)  strb.rdSel = RD_WIDTH;
      else if (addr32 == OFF_VDISP)  strb.rdSel = RD_HEIGHT;
      else if (addr32 == OFF_CTL)    strb.rdSel = RD_CTL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspReady <= 1'b0;
      frameIrq <= 1'b0;
    end else begin
      rspReady <= reqValid;
      if (frameStrobe)  frameIrq <= 1'b1;
      else if (doWr)    frameIrq <= 1'b0;
    end
  end

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspReady); // R1
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspReady); // R1
  AST_IRQ_SET_BY_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> frameIrq); // R10
  AST_IRQ_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (doWr && !frameStrobe) |=> !frameIrq); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!doWr && !frameStrobe) |=> $stable(frameIrq)); // R10
  AST_TIMING_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (doWr && hitTiming) |-> !(strb.wrWidth || strb.wrHeight || strb.wrCtl || strb.wrTop ||
                              strb.wrCurPos || strb.wrPal || strb.wrCurPal || strb.wrPat ||
                              strb.softReset)); // R9

endmodule

// File: rtl/dcr_store.sv
module dcr_store import dcr_pkg::*; #(
  parameter  int DATA_W   = 32,
  parameter  int PAL_N    = 256,
  parameter  int PAT_N    = 512,
  parameter  int CURPAL_N = 3,
  localparam int PAL_IW   = $clog2(PAL_N),
  localparam int PAT_IW   = $clog2(PAT_N),
  localparam int CP_IW    = $clog2(CURPAL_N + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   ctlReg,
  output logic [DATA_W-1:0]   topReg,
  output logic [DATA_W-1:0]   posReg,
  output logic [DATA_W-1:0]   widthReg,
  output logic [DATA_W-1:0]   heightReg,
  input  logic [PAL_IW-1:0]   palIdx,
  output logic [RGB_W-1:0]    palRgb,
  input  logic [CP_IW-1:0]    curPalIdx,
  output logic [RGB_W-1:0]    curPalRgb,
  input  logic [PAT_IW-1:0]   patIdx,
  output logic [PAT_W-1:0]    patWord
);

  logic [PAL_IW-1:0] palBusIdx;
  logic [PAT_IW-1:0] patBusIdx;
  logic [CP_IW-1:0]  cpBusIdx;

  assign palBusIdx = strb.idx[PAL_IW-1:0];
  assign patBusIdx = strb.idx[PAT_IW-1:0];
  assign cpBusIdx  = strb.idx[CP_IW-1:0];

  // Table contents carry no reset; a per-entry live bit masks stale data.
  logic [RGB_W-1:0] palMem [PAL_N];
  logic [PAL_N-1:0] palVld;
  logic [PAT_W-1:0] patMem [PAT_N];
  logic [PAT_N-1:0] patVld;

  always_ff @(posedge clk) begin
    if (strb.wrPal) palMem[palBusIdx] <= wrData[RGB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.wrPat) patMem[patBusIdx] <= wrData[PAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      palVld <= '0;
      patVld <= '0;
    end else if (strb.softReset) begin
      palVld <= '0;
      patVld <= '0;
    end else begin
      if (strb.wrPal) palVld[palBusIdx] <= 1'b1;
      if (strb.wrPat) patVld[patBusIdx] <= 1'b1;
    end
  end

  logic [CURPAL_N-1:0][RGB_W-1:0] curPalW;

  for (genvar g = 0; g < CURPAL_N; g++) begin : gCurPal
    logic [RGB_W-1:0] ent;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         ent <= '0;
      else if (strb.softReset)                           ent <= '0;
      else if (strb.wrCurPal && (cpBusIdx == CP_IW'(g))) ent <= wrData[RGB_W-1:0];
    end
    assign curPalW[g] = ent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg    <= '0;
      topReg    <= '0;
      posReg    <= '0;
      widthReg  <= '0;
      heightReg <= '0;
    end else if (strb.softReset) begin
      ctlReg    <= '0;
      topReg    <= '0;
      posReg    <= '0;
      widthReg  <= '0;
      heightReg <= '0;
    end else begin
      if (strb.wrCtl)    ctlReg    <= wrData;
      if (strb.wrTop)    topReg    <= wrData;
      if (strb.wrCurPos) posReg    <= wrData;
      if (strb.wrWidth)  widthReg  <= {wrData[DATA_W-3:0], 2'b00};
      if (strb.wrHeight) heightReg <= {1'b0, wrData[DATA_W-1:1]};
    end
  end

  logic [RGB_W-1:0]  busCurPal;
  logic [PAT_W-1:0]  busPat;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    busCurPal = '0;
    curPalRgb = '0;
    for (int i = 0; i < CURPAL_N; i++) begin
      if (cpBusIdx == CP_IW'(i))  busCurPal = curPalW[i];
      if (curPalIdx == CP_IW'(i)) curPalRgb = curPalW[i];
    end
  end

  assign busPat  = patVld[patBusIdx] ? patMem[patBusIdx] : '0;
  assign patWord = patVld[patIdx]    ? patMem[patIdx]    : '0;
  assign palRgb  = palVld[palIdx]    ? palMem[palIdx]    : '0;

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_WIDTH:  rdNext = {2'b00, widthReg[DATA_W-1:2]};
      RD_HEIGHT: rdNext = {heightReg[DATA_W-2:0], 1'b0};
      RD_CTL:    rdNext = ctlReg;
      RD_CURPAL: rdNext = DATA_W'(busCurPal);
      RD_PAT:    rdNext = DATA_W'(busPat);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  AST_SRST_CLEARS_REGS: assert property (@(posedge clk) disable iff (!rstN)
    strb.softReset |=> (ctlReg == '0 && topReg == '0 && posReg == '0 &&
                        widthReg == '0 && heightReg == '0 && curPalW == '0)); // R11
  AST_SRST_CLEARS_TABLES: assert property (@(posedge clk) disable iff (!rstN)
    strb.softReset |=> (palVld == '0 && patVld == '0)); // R11
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_NONE) |=> (rdData == '0)); // R8
  AST_PAL_ENTRY_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPal && !strb.softReset) |=> palVld[$past(palBusIdx)]); // R4
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCtl && !strb.softReset) |=> $stable(ctlReg)); // R9

endmodule

// File: rtl/dcr_top.sv
module dcr_top import dcr_pkg::*; #(
  parameter  int ADDR_W   = 21,
  parameter  int DATA_W   = 32,
  parameter  int PAL_N    = 256,
  parameter  int PAT_N    = 512,
  parameter  int CURPAL_N = 3,
  localparam int PAL_IW   = $clog2(PAL_N),
  localparam int PAT_IW   = $clog2(PAT_N),
  localparam int CP_IW    = $clog2(CURPAL_N + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspReady,
  output logic [DATA_W-1:0]  rspRdata,
  input  logic               frameStrobe,
  output logic               frameIrq,
  output logic [DATA_W-1:0]  ctlWord,
  output logic [DEPTH_W-1:0] pixDepth,
  output logic               forceBlank,
  output logic               cursorOff,
  output logic [DATA_W-1:0]  screenTop,
  output logic [DATA_W-1:0]  cursorPos,
  output logic [DATA_W-1:0]  activeWidth,
  output logic [DATA_W-1:0]  activeHeight,
  input  logic [PAL_IW-1:0]  palIdx,
  output logic [RGB_W-1:0]   palRgb,
  input  logic [CP_IW-1:0]   curPalIdx,
  output logic [RGB_W-1:0]   curPalRgb,
  input  logic [PAT_IW-1:0]  patIdx,
  output logic [PAT_W-1:0]   patWord
);

  regStrobe_t strb;

  dcr_ctrl #(
    .ADDR_W(ADDR_W), .PAL_N(PAL_N), .PAT_N(PAT_N), .CURPAL_N(CURPAL_N)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .frameStrobe(frameStrobe), .strb(strb),
    .rspReady(rspReady), .frameIrq(frameIrq)
  );

  dcr_store #(
    .DATA_W(DATA_W), .PAL_N(PAL_N), .PAT_N(PAT_N), .CURPAL_N(CURPAL_N)
  ) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(reqWdata), .rdData(rspRdata),
    .ctlReg(ctlWord), .topReg(screenTop), .posReg(cursorPos),
    .widthReg(activeWidth), .heightReg(activeHeight),
    .palIdx(palIdx), .palRgb(palRgb), .curPalIdx(curPalIdx), .curPalRgb(curPalRgb),
    .patIdx(patIdx), .patWord(patWord)
  );

  assign forceBlank = ctlWord[10];
  assign cursorOff  = ctlWord[23];
  assign pixDepth   = depthOf(ctlWord[22:20]);

endmodule

// File: tb/sim_dcr_top.sv
module sim_dcr_top;

  localparam int CLK_PERIOD = 10;
  localparam int PAL_N = 256;
  localparam int PAT_N = 512;
  localparam int CURPAL_N = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        frameStrobe = 1'b0;
  logic [7:0]  palIdx = '0;
  logic [1:0]  curPalIdx = '0;
  logic [8:0]  patIdx = '0;

  logic        rspReady, frameIrq, forceBlank, cursorOff;
  logic [31:0] rspRdata, ctlWord, screenTop, cursorPos, activeWidth, activeHeight;
  logic [4:0]  pixDepth;
  logic [23:0] palRgb, curPalRgb;
  logic [15:0] patWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcr_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady), .rspRdata(rspRdata),
    .frameStrobe(frameStrobe), .frameIrq(frameIrq), .ctlWord(ctlWord),
    .pixDepth(pixDepth), .forceBlank(forceBlank), .cursorOff(cursorOff),
    .screenTop(screenTop), .cursorPos(cursorPos), .activeWidth(activeWidth),
    .activeHeight(activeHeight), .palIdx(palIdx), .palRgb(palRgb),
    .curPalIdx(curPalIdx), .curPalRgb(curPalRgb), .patIdx(patIdx), .patWord(patWord)
  );

  int    vectors = 0;
  int    fails = 0;
  bit    armed = 0;
  string scen = "R12 reset";

  // Behavioural reference state
  bit [31:0] mPal [PAL_N];
  bit [31:0] mCur [CURPAL_N];
  bit [15:0] mPat [PAT_N];
  bit [31:0] mCtl, mTop, mPos, mWid, mHgt, mRdata;
  bit        mReady, mIrq, mRdValid;
  string     mRdTag = "R8";

  function automatic bit [4:0] depthRef(input bit [2:0] c);
    int tbl [8] = '{1, 2, 4, 8, 15, 16, 0, 0};
    return 5'(tbl[c]);
  endfunction

  task automatic modelClear();
    for (int i = 0; i < PAL_N; i++) mPal[i] = 0;
    for (int i = 0; i < PAT_N; i++) mPat[i] = 0;
    for (int i = 0; i < CURPAL_N; i++) mCur[i] = 0;
    mCtl = 0; mTop = 0; mPos = 0; mWid = 0; mHgt = 0;
  endtask

  task automatic modelRead(input bit [31:0] a);
    mRdata = 0;
    mRdTag = "R8";
    if (a >= 32'h800 && a < 32'h1000) mRdTag = "R4";
    else if (a >= 32'h508 && a < 32'h520) begin mRdTag = "R5"; mRdata = mCur[(a - 32'h508) >> 3]; end
    else if (a >= 32'h1000 && a < 32'h2000) begin mRdTag = "R6"; mRdata = {16'h0, mPat[(a - 32'h1000) >> 3]}; end
    else if (a == 32'h118) begin mRdTag = "R2"; mRdata = mWid >> 2; end
    else if (a == 32'h150) begin mRdTag = "R3"; mRdata = mHgt << 1; end
    else if (a == 32'h300) begin mRdTag = "R7"; mRdata = mCtl; end
  endtask

  task automatic modelWrite(input bit [31:0] a, input bit [31:0] d);
    if (a >= 32'h800 && a < 32'h1000) mPal[(a - 32'h800) >> 3] = d & 32'h00FF_FFFF;
    else if (a >= 32'h508 && a < 32'h520) mCur[(a - 32'h508) >> 3] = d & 32'h00FF_FFFF;
    else if (a >= 32'h1000 && a < 32'h2000) mPat[(a - 32'h1000) >> 3] = d[15:0];
    else if (a == 32'h118) mWid = d << 2;
    else if (a == 32'h150) mHgt = d >> 1;
    else if (a == 32'h300) mCtl = d;
    else if (a == 32'h400) mTop = d;
    else if (a == 32'h638) mPos = d;
    else if (a == 32'h0010_0000) modelClear();
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      modelClear();
      mReady = 0; mIrq = 0; mRdValid = 0; mRdata = 0;
    end else begin
      mReady   = reqValid;
      mRdValid = reqValid && !reqWrite;
      if (frameStrobe) mIrq = 1;
      else if (reqValid && reqWrite) mIrq = 0;
      if (reqValid && !reqWrite) modelRead(32'(reqAddr));
      if (reqValid && reqWrite)  modelWrite(32'(reqAddr), reqWdata);
    end
  end

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s]: actual %0h expected %0h at %0t", scen, tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R1 ready", 32'(rspReady), 32'(mReady));
      if (mRdValid) chk(mRdTag, rspRdata, mRdata);
      if (!rstN) chk("R12 rdata", rspRdata, 32'h0);
      chk("R10 irq", 32'(frameIrq), 32'(mIrq));
      chk("R2 width", activeWidth, mWid);
      chk("R3 height", activeHeight, mHgt);
      chk("R7 ctl", ctlWord, mCtl);
      chk("R7 depth", 32'(pixDepth), 32'(depthRef(mCtl[22:20])));
      chk("R7 blank", 32'(forceBlank), 32'(mCtl[10]));
      chk("R7 cursorOff", 32'(cursorOff), 32'(mCtl[23]));
      chk("R8 top", screenTop, mTop);
      chk("R8 pos", cursorPos, mPos);
      chk("R4 palRgb", 32'(palRgb), mPal[palIdx]);
      chk("R5 curPalRgb", 32'(curPalRgb), (curPalIdx < 2'd3) ? mCur[curPalIdx] : 32'h0);
      chk("R6 patWord", 32'(patWord), 32'(mPat[patIdx]));
    end
  end

  task automatic busOp(input bit w, input bit [31:0] a, input bit [31:0] d, input bit s = 1'b0);
    reqValid = 1'b1; reqWrite = w; reqAddr = 21'(a); reqWdata = d; frameStrobe = s;
    @(posedge clk); #1;
    reqValid = 1'b0; reqWrite = 1'b0; frameStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  bit [31:0] tOffs [14] = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
                            32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200};

  initial begin
    bit [31:0] lf;
    bit [31:0] a;
    lf = 32'hACE1_2345;
    rstN = 1'b0;
    @(posedge clk); #1;
    armed = 1;
    idle(2);
    rstN = 1'b1;
    idle(1);

    scen = "R2 width";
    busOp(1, 32'h118, 32'h140);
    busOp(0, 32'h118, 0);
    busOp(1, 32'h118, 32'hFFFF_FFFF);
    busOp(0, 32'h118, 0);

    scen = "R3 height";
    busOp(1, 32'h150, 32'h301);
    busOp(0, 32'h150, 0);
    busOp(1, 32'h150, 32'hFFFF_FFFF);
    busOp(0, 32'h150, 0);

    scen = "R7 control";
    for (int c = 0; c < 8; c++) begin
      busOp(1, 32'h300, (32'(c) << 20) | (c[0] ? 32'h400 : 32'h0) | (c[1] ? 32'h80_0000 : 32'h0));
      busOp(0, 32'h300, 0);
    end

    scen = "R4 palette";
    busOp(1, 32'h800, 32'hFFAA_BBCC);
    busOp(1, 32'h804, 32'h1122_3344);
    busOp(1, 32'hFF8, 32'hFF12_3456);
    busOp(1, 32'h818, 32'h0000_00FF);
    busOp(0, 32'h800, 0);
    for (int i = 0; i < 4; i++) begin palIdx = 8'(i); idle(1); end
    palIdx = 8'd255; idle(1);

    scen = "R5 cursor palette";
    busOp(1, 32'h508, 32'h0001_0203);
    busOp(1, 32'h510, 32'hAB80_40C0);
    busOp(1, 32'h518, 32'h00FF_FFFF);
    busOp(1, 32'h520, 32'h00FF_FFFF);
    busOp(0, 32'h508, 0);
    busOp(0, 32'h510, 0);
    busOp(0, 32'h51C, 0);
    busOp(0, 32'h520, 0);
    for (int i = 0; i < 4; i++) begin curPalIdx = 2'(i); idle(1); end

    scen = "R6 pattern";
    busOp(1, 32'h1000, 32'hABCD_1234);
    busOp(1, 32'h100C, 32'h0000_5555);
    busOp(1, 32'h1FF8, 32'h0000_BEEF);
    busOp(0, 32'h1000, 0);
    busOp(0, 32'h1008, 0);
    busOp(0, 32'h1FF8, 0);
    patIdx = 9'd1; idle(1);
    patIdx = 9'd511; idle(1);

    scen = "R8 write-only and undefined";
    busOp(1, 32'h400, 32'h0012_3400);
    busOp(1, 32'h638, 32'h0040_0030);
    busOp(0, 32'h400, 0);
    busOp(0, 32'h638, 0);
    busOp(0, 32'h2000, 0);
    busOp(0, 32'h0010_0000, 0);

    scen = "R9 timing writes ignored";
    foreach (tOffs[k]) busOp(1, tOffs[k], 32'hFFFF_FFFF);
    busOp(1, 32'h7FC, 32'hFFFF_FFFF);
    busOp(0, 32'h118, 0);
    busOp(0, 32'h150, 0);
    busOp(0, 32'h300, 0);

    scen = "R10 interrupt";
    busOp(0, 32'h300, 0, 1'b1);
    idle(2);
    busOp(0, 32'h118, 0);
    busOp(1, 32'h000, 0);
    idle(1);
    frameStrobe = 1'b1; idle(1); frameStrobe = 1'b0;
    busOp(1, 32'h200, 0, 1'b1);
    idle(1);
    busOp(1, 32'h900, 32'h0000_0101);

    scen = "R11 soft reset";
    busOp(0, 32'h300, 0, 1'b1);
    palIdx = 8'd255; patIdx = 9'd511; curPalIdx = 2'd1;
    busOp(1, 32'h0010_0000, 0);
    busOp(0, 32'h510, 0);
    busOp(0, 32'h1FF8, 0);
    busOp(0, 32'h118, 0);
    busOp(0, 32'h300, 0);
    palIdx = 8'd0; patIdx = 9'd0; idle(1);

    scen = "R1 mixed traffic";
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[3:0])
        4'd0, 4'd1, 4'd2: a = 32'h800 + {21'h0, lf[14:7], 3'b000};
        4'd3, 4'd4:       a = 32'h1000 + {20'h0, lf[16:8], 3'b000};
        4'd5:             a = 32'h508 + (32'(lf[9:8]) << 3);
        4'd6:             a = 32'h118;
        4'd7:             a = 32'h150;
        4'd8:             a = 32'h300;
        4'd9:             a = 32'h400;
        4'd10:            a = 32'h638;
        4'd11:            a = 32'h200;
        4'd12:            a = (lf[20:16] == 5'd0) ? 32'h0010_0000 : 32'h300;
        default:          a = 32'h2000 + {20'h0, lf[11:0]};
      endcase
      palIdx = lf[27:20];
      patIdx = lf[30:22];
      curPalIdx = lf[5:4];
      busOp(lf[31], a, {lf[15:0], lf[31:16]} ^ 32'h5A5A_A5A5, lf[25] & lf[26]);
      if (lf[6] & lf[7]) idle(1);
    end

    idle(2);
    summary();
    $finish;
  end

endmodule